// File: doc/BRIEF.md
# Register-Driven Atomic Reservation Unit

This unit lets a processor perform a load-linked / store-conditional style read-modify-write on one memory word using only register accesses. Software writes a word address into the address register. The unit clears its status, fetches that word over a single-word memory master port, and places the value in the data register. Software reads the data register, computes a new value and writes it back to the data register. That write is the conditional store.

While the reservation is open, the unit watches three event inputs: a write by another agent to the watched word, a bus lock held by another master, and interrupt entry. It also watches for a bus error on the fetch. Each of these causes sets its own status flag. When any flag is set at the time of the data-register write, no store is sent to memory. A bus error on the store itself sets the error flag after the store has been issued. Software treats the update as successful only when all four flags read back as zero.

The register port is a valid/ready slave. The unit holds `reg_ready` low to apply back-pressure in three cases: a data read while the fetch is in flight, an address write while a memory transaction is outstanding, and a data write while a memory transaction is outstanding. The memory request is valid/ready. At most one request is outstanding, and its response comes back on a one-cycle `mem_rsp_valid` strobe.

Top module: `atomic_resv_unit`

## Requirements
- R1: Register offsets are 0 = address, 1 = data, 2 = status. A write to offset 0 issues one memory read of that word on the next cycle. Once that read returns, a read of offset 1 gives the fetched word. After reset every register reads as zero.
- R2: A write to the address register clears all four status flags, including while a reservation is already open.
- R3: A data-register read issued while the fetch is outstanding holds `reg_ready` low until the fetched value is loaded, then returns that value.
- R4: A data-register write made while the reservation is open, with no flag set and no event in that cycle, issues exactly one memory write of that value to the watched word address.
- R5: Status bit 0 is the conflicting-write flag, bit 1 the lock flag, bit 2 the interrupt flag and bit 3 the bus-error flag; all other bits read as zero. Writes to offset 2 are ignored, and offset 3 reads as zero.
- R6: The watch window runs from the cycle after the address write through the cycle of the data write. Within it, `snoop_wr_valid` with `snoop_wr_addr` equal to the watched address sets bit 0, while a snoop to any other address has no effect. `lock_held` sets bit 1 and `irq_taken` sets bit 2.
- R7: An error response to either the fetch or the store sets bit 3.
- R8: When any flag is set, counting events present in the data-write cycle itself, the data write issues no memory request and memory keeps its old value.
- R9: The reservation closes after the store is issued or suppressed. A later data write then issues no memory request and leaves the flags unchanged, and events that arrive afterwards set no flag.
- R10: `mem_req_valid` stays high, and address, direction and write data stay stable, until `mem_req_ready`. Only one request is outstanding at a time.
- R11: Address and data writes hold `reg_ready` low while a fetch or a store is outstanding, and complete once the transaction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Register access accepted this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data, valid when reg_valid and reg_ready are both high on a read |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = store, 0 = fetch |
| mem_req_addr | output | ADDR_W | Word address |
| mem_req_wdata | output | DATA_W | Store data |
| mem_rsp_valid | input | 1 | One-cycle response strobe |
| mem_rsp_data | input | DATA_W | Fetched word |
| mem_rsp_err | input | 1 | Response carries a bus error |
| snoop_wr_valid | input | 1 | Another agent writes memory this cycle |
| snoop_wr_addr | input | ADDR_W | Word address of that write |
| lock_held | input | 1 | Another master holds a bus lock |
| irq_taken | input | 1 | Interrupt entry this cycle |

## Verification
The bench targets several corner cases, each with the failure it would catch:
- A conflicting write that arrives in the same cycle as the data write. A design that decided only from the registered flags would store anyway and corrupt memory.
- A snoop to a neighbouring address. A design that flagged on any snoop would abort updates for no reason.
- A store bus error, which must raise the error flag even though the write was issued.
- A second data write after the reservation has closed. A careless design would issue a second store or disturb the flags.
- Rewriting the address while a reservation is open, which must clear flags already set.
- Data reads and writes issued straight after the address write, which must stall rather than return stale data or race the fetch.

// File: rtl/aru_pkg.sv
package aru_pkg;
  localparam int FLAG_N  = 4;
  localparam int FL_RW   = 0;
  localparam int FL_LW   = 1;
  localparam int FL_IW   = 2;
  localparam int FL_BW   = 3;

  localparam logic [1:0] OFF_ADDR = 2'd0;
  localparam logic [1:0] OFF_DATA = 2'd1;
  localparam logic [1:0] OFF_STAT = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RESV, S_STORE} resv_state_e;
  typedef enum logic [1:0] {M_IDLE, M_REQ, M_RSP} mem_state_e;
endpackage

// File: rtl/aru_mem_port.sv
module aru_mem_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_write_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_data_i,
  input  logic              mem_rsp_err_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  import aru_pkg::*;

  mem_state_e        st_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= M_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st_q)
        M_IDLE: if (start_i) begin
          st_q    <= M_REQ;
          wr_q    <= wr_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
        end
        M_REQ:  if (mem_req_ready_i) st_q <= M_RSP;
        M_RSP:  if (mem_rsp_valid_i) st_q <= M_IDLE;
        default: st_q <= M_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (st_q == M_REQ);
  assign mem_req_write_o = wr_q;
  assign mem_req_addr_o  = addr_q;
  assign mem_req_wdata_o = wdata_q;
  assign done_o          = (st_q == M_RSP) && mem_rsp_valid_i;
  assign rdata_o         = mem_rsp_data_i;
  assign err_o           = mem_rsp_err_i;
endmodule

// File: rtl/aru_watch.sv
module aru_watch #(
  parameter int ADDR_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear_i,
  input  logic                      window_i,
  input  logic [ADDR_W-1:0]         watch_addr_i,
  input  logic                      snoop_valid_i,
  input  logic [ADDR_W-1:0]         snoop_addr_i,
  input  logic                      lock_i,
  input  logic                      irq_i,
  input  logic                      bus_err_i,
  output logic [aru_pkg::FLAG_N-1:0] flags_o,
  output logic                      any_next_o
);
  import aru_pkg::*;

  logic [FLAG_N-1:0] ev;

  always_comb begin
    ev        = '0;
    ev[FL_RW] = window_i && snoop_valid_i && (snoop_addr_i == watch_addr_i);
    ev[FL_LW] = window_i && lock_i;
    ev[FL_IW] = window_i && irq_i;
    ev[FL_BW] = bus_err_i;
  end

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)         flags_o[g] <= 1'b0;
      else if (clear_i)   flags_o[g] <= 1'b0;
      else if (ev[g])     flags_o[g] <= 1'b1;
    end
  end

  assign any_next_o = |(flags_o | ev);
endmodule

// File: rtl/aru_ctrl.sv
module aru_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_valid_i,
  input  logic                       reg_write_i,
  input  logic [1:0]                 reg_addr_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  output logic                       reg_ready_o,
  output logic [DATA_W-1:0]          reg_rdata_o,
  input  logic [aru_pkg::FLAG_N-1:0] flags_i,
  input  logic                       any_next_i,
  input  logic                       mem_done_i,
  input  logic [DATA_W-1:0]          mem_rdata_i,
  input  logic                       mem_err_i,
  output logic                       mem_start_o,
  output logic                       mem_wr_o,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic [DATA_W-1:0]          mem_wdata_o,
  output logic                       watch_clear_o,
  output logic                       window_o,
  output logic [ADDR_W-1:0]          watch_addr_o,
  output logic                       bus_err_o,
  output aru_pkg::resv_state_e       state_o
);
  import aru_pkg::*;

  localparam int PAD_A = DATA_W - ADDR_W;
  localparam int PAD_F = DATA_W - FLAG_N;

  resv_state_e       st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              can_write;
  logic              fire, addr_wr, data_wr;

  assign can_write = (st_q == S_IDLE) || (st_q == S_RESV);

  always_comb begin
    unique case (reg_addr_i)
      OFF_ADDR: reg_ready_o = !reg_write_i || can_write;
      OFF_DATA: reg_ready_o = reg_write_i ? can_write : (st_q != S_FETCH);
      default:  reg_ready_o = 1'b1;
    endcase
  end

  always_comb begin
    unique case (reg_addr_i)
      OFF_ADDR: reg_rdata_o = {{PAD_A{1'b0}}, addr_q};
      OFF_DATA: reg_rdata_o = data_q;
      OFF_STAT: reg_rdata_o = {{PAD_F{1'b0}}, flags_i};
      default:  reg_rdata_o = '0;
    endcase
  end

  assign fire    = reg_valid_i && reg_ready_o;
  assign addr_wr = fire && reg_write_i && (reg_addr_i == OFF_ADDR);
  assign data_wr = fire && reg_write_i && (reg_addr_i == OFF_DATA);

  assign mem_start_o   = addr_wr || (data_wr && (st_q == S_RESV) && !any_next_i);
  assign mem_wr_o      = data_wr;
  assign mem_addr_o    = data_wr ? addr_q : reg_wdata_i[ADDR_W-1:0];
  assign mem_wdata_o   = reg_wdata_i;
  assign watch_clear_o = addr_wr;
  assign window_o      = (st_q == S_FETCH) || (st_q == S_RESV);
  assign watch_addr_o  = addr_q;
  assign bus_err_o     = mem_done_i && mem_err_i;
  assign state_o       = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      data_q <= '0;
    end else if (addr_wr) begin
      addr_q <= reg_wdata_i[ADDR_W-1:0];
      st_q   <= S_FETCH;
    end else begin
      unique case (st_q)
        S_IDLE:  if (data_wr) data_q <= reg_wdata_i;
        S_FETCH: if (mem_done_i) begin
          data_q <= mem_rdata_i;
          st_q   <= S_RESV;
        end
        S_RESV:  if (data_wr) begin
          data_q <= reg_wdata_i;
          st_q   <= any_next_i ? S_IDLE : S_STORE;
        end
        S_STORE: if (mem_done_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/atomic_resv_unit.sv
module atomic_resv_unit #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_write,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  input  logic              snoop_wr_valid,
  input  logic [ADDR_W-1:0] snoop_wr_addr,
  input  logic              lock_held,
  input  logic              irq_taken
);
  import aru_pkg::*;

  logic [FLAG_N-1:0] flags_w;
  logic              any_nxt_w;
  logic              done_w, merr_w, start_w, wr_w;
  logic [DATA_W-1:0] mrdata_w, mwdata_w;
  logic [ADDR_W-1:0] maddr_w, watch_addr_w;
  logic              clear_w, window_w, berr_w;
  resv_state_e       state_w;

  aru_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_valid_i(reg_valid), .reg_write_i(reg_write), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_ready_o(reg_ready), .reg_rdata_o(reg_rdata),
    .flags_i(flags_w), .any_next_i(any_nxt_w),
    .mem_done_i(done_w), .mem_rdata_i(mrdata_w), .mem_err_i(merr_w),
    .mem_start_o(start_w), .mem_wr_o(wr_w), .mem_addr_o(maddr_w), .mem_wdata_o(mwdata_w),
    .watch_clear_o(clear_w), .window_o(window_w), .watch_addr_o(watch_addr_w),
    .bus_err_o(berr_w), .state_o(state_w)
  );

  aru_watch #(.ADDR_W(ADDR_W)) i_watch (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_w), .window_i(window_w),
    .watch_addr_i(watch_addr_w), .snoop_valid_i(snoop_wr_valid),
    .snoop_addr_i(snoop_wr_addr), .lock_i(lock_held), .irq_i(irq_taken),
    .bus_err_i(berr_w), .flags_o(flags_w), .any_next_o(any_nxt_w)
  );

  aru_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .wr_i(wr_w),
    .addr_i(maddr_w), .wdata_i(mwdata_w),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_write_o(mem_req_write), .mem_req_addr_o(mem_req_addr),
    .mem_req_wdata_o(mem_req_wdata), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data), .mem_rsp_err_i(mem_rsp_err),
    .done_o(done_w), .rdata_o(mrdata_w), .err_o(merr_w)
  );
endmodule

// File: rtl/aru_checker.sv
module aru_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_valid,
  input logic                       reg_ready,
  input logic                       reg_write,
  input logic [1:0]                 reg_addr,
  input logic [DATA_W-1:0]          reg_wdata,
  input logic                       mem_req_valid,
  input logic                       mem_req_ready,
  input logic                       mem_req_write,
  input logic [ADDR_W-1:0]          mem_req_addr,
  input logic [DATA_W-1:0]          mem_req_wdata,
  input logic                       irq_taken,
  input logic [aru_pkg::FLAG_N-1:0] flags,
  input logic                       any_next,
  input logic [ADDR_W-1:0]          watch_addr,
  input aru_pkg::resv_state_e       state
);
  import aru_pkg::*;

  logic fire_w, addr_fire, data_fire;
  assign fire_w    = reg_valid && reg_ready && reg_write;
  assign addr_fire = fire_w && (reg_addr == OFF_ADDR);
  assign data_fire = fire_w && (reg_addr == OFF_DATA);

  AST_FETCH_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    addr_fire |=> mem_req_valid && !mem_req_write && (mem_req_addr == $past(reg_wdata[ADDR_W-1:0]))); // R1
  AST_ADDR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_fire |=> (flags == '0)); // R2
  AST_READ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_write && reg_addr == OFF_DATA && state == S_FETCH) |-> !reg_ready); // R3
  AST_CLEAN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && state == S_RESV && !any_next) |=> mem_req_valid && mem_req_write
      && (mem_req_wdata == $past(reg_wdata)) && (mem_req_addr == $past(watch_addr))); // R4
  AST_IRQ_WATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_taken && state == S_RESV && !addr_fire) |=> flags[FL_IW]); // R6
  AST_NO_FLAGGED_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (flags == '0)); // R8
  AST_STALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && state == S_IDLE) |=> !mem_req_valid && $stable(flags)); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)); // R10
  AST_WRITE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && (reg_addr == OFF_ADDR || reg_addr == OFF_DATA)
      && (state == S_FETCH || state == S_STORE)) |-> !reg_ready); // R11
endmodule

bind atomic_resv_unit aru_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_aru_checker (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
  .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .irq_taken(irq_taken), .flags(flags_w),
  .any_next(any_nxt_w), .watch_addr(watch_addr_w), .state(state_w)
);

// File: tb/test_atomic_resv_unit.sv
module test_atomic_resv_unit;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [DW-1:0] INIT_BASE = 32'hA500_0000;
  localparam logic [DW-1:0] NEW_BASE  = 32'h5A5A_0000;

  // {event[2:0], fetch_err, store_err, expected_flags[3:0], expected_store}
  // event: 0 none, 1 snoop same word, 2 snoop next word, 3 lock, 4 irq, 5 snoop in data-write cycle
  localparam int NV = 8;
  localparam logic [9:0] VECS [NV] = '{
    {3'd0, 1'b0, 1'b0, 4'b0000, 1'b1},
    {3'd1, 1'b0, 1'b0, 4'b0001, 1'b0},
    {3'd2, 1'b0, 1'b0, 4'b0000, 1'b1},
    {3'd3, 1'b0, 1'b0, 4'b0010, 1'b0},
    {3'd4, 1'b0, 1'b0, 4'b0100, 1'b0},
    {3'd0, 1'b1, 1'b0, 4'b1000, 1'b0},
    {3'd0, 1'b0, 1'b1, 4'b1000, 1'b1},
    {3'd5, 1'b0, 1'b0, 4'b0001, 1'b0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n;

  logic          reg_valid, reg_write, reg_ready;
  logic [1:0]    reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic          mem_req_valid, mem_req_ready, mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata, mem_rsp_data;
  logic          mem_rsp_valid, mem_rsp_err;
  logic          snoop_wr_valid, lock_held, irq_taken;
  logic [AW-1:0] snoop_wr_addr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int store_cnt = 0;
  logic ferr_inj = 1'b0, serr_inj = 1'b0;
  logic [DW-1:0] mem [16];
  logic          pend, p_wr, held_v;
  logic [1:0]    lat;
  logic [3:0]    p_a;
  logic [DW-1:0] p_d;
  logic [AW-1:0] held_a;

  atomic_resv_unit #(.ADDR_W(AW), .DATA_W(DW)) i_atomic_resv_unit (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err), .snoop_wr_valid(snoop_wr_valid),
    .snoop_wr_addr(snoop_wr_addr), .lock_held(lock_held), .irq_taken(irq_taken)
  );

  // memory model: one wait state before ready, response three cycles after acceptance
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      pend <= 1'b0;
      held_v <= 1'b0;
      lat <= '0;
      mem_rsp_err <= 1'b0;
      mem_rsp_data <= '0;
      for (int k = 0; k < 16; k++) mem[k] <= INIT_BASE | DW'(k);
    end else begin
      mem_req_ready <= mem_req_valid && !mem_req_ready && !pend;
      if (mem_req_valid && !mem_req_ready) begin
        held_v <= 1'b1;
        held_a <= mem_req_addr;
      end
      if (mem_req_valid && mem_req_ready) begin
        if (held_v) begin
          checks = checks + 1;
          if (mem_req_addr !== held_a) begin
            fails = fails + 1;
            $display("FAIL R10 request address moved: actual %h expected %h", mem_req_addr, held_a);
          end
        end
        held_v <= 1'b0;
        pend <= 1'b1;
        lat <= 2'd2;
        p_wr <= mem_req_write;
        p_a <= mem_req_addr[3:0];
        p_d <= mem_req_wdata;
        if (mem_req_write) store_cnt <= store_cnt + 1;
      end else if (pend) begin
        if (lat != 0) lat <= lat - 2'd1;
        else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_err <= p_wr ? serr_inj : ferr_inj;
          mem_rsp_data <= mem[p_a];
          if (p_wr && !serr_inj) mem[p_a] <= p_d;
          pend <= 1'b0;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles == 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [1:0] off, input logic [DW-1:0] wd,
                      input logic snoop_now, input logic [AW-1:0] saddr,
                      output logic [DW-1:0] rd, output int waits);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = wr; reg_addr = off; reg_wdata = wd; waits = 0;
    if (snoop_now) begin snoop_wr_valid = 1'b1; snoop_wr_addr = saddr; end
    forever begin
      #2;
      if (reg_ready) begin rd = reg_rdata; break; end
      @(negedge clk);
      waits++;
    end
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; snoop_wr_valid = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] off, input logic [DW-1:0] wd);
    logic [DW-1:0] d; int w;
    xfer(1'b1, off, wd, 1'b0, '0, d, w);
  endtask

  task automatic rd_reg(input logic [1:0] off, output logic [DW-1:0] d);
    int w;
    xfer(1'b0, off, '0, 1'b0, '0, d, w);
  endtask

  task automatic pulse(input int kind, input logic [AW-1:0] a);
    @(negedge clk);
    case (kind)
      1: begin snoop_wr_valid = 1'b1; snoop_wr_addr = a; end
      3: lock_held = 1'b1;
      4: irq_taken = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    snoop_wr_valid = 1'b0; lock_held = 1'b0; irq_taken = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] d, nv;
    int w, base;
    rst_n = 1'b0;
    reg_valid = 1'b0; reg_write = 1'b0; reg_addr = '0; reg_wdata = '0;
    snoop_wr_valid = 1'b0; snoop_wr_addr = '0; lock_held = 1'b0; irq_taken = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd_reg(2'd2, d); check("R5 status after reset", d, '0);
    rd_reg(2'd1, d); check("R1 data after reset", d, '0);
    rd_reg(2'd0, d); check("R1 address after reset", d, '0);
    check("R10 no request after reset", DW'(mem_req_valid), '0);

    // table-driven scenarios
    for (int i = 0; i < NV; i++) begin
      logic [9:0] v;
      v = VECS[i];
      ferr_inj = v[6]; serr_inj = v[5];
      base = store_cnt;
      nv = NEW_BASE + DW'(i);
      wr_reg(2'd0, DW'(i));
      rd_reg(2'd1, d); check("R1 R10 fetched word", d, INIT_BASE | DW'(i));
      case (v[9:7])
        3'd1: pulse(1, AW'(i));
        3'd2: pulse(1, AW'(i + 1));
        3'd3: pulse(3, '0);
        3'd4: pulse(4, '0);
        default: ;
      endcase
      xfer(1'b1, 2'd1, nv, v[9:7] == 3'd5, AW'(i), d, w);
      repeat (8) @(negedge clk);
      rd_reg(2'd2, d); check("R5 R6 R7 R8 status flags", d, DW'(v[4:1]));
      check("R4 R8 store count", DW'(store_cnt - base), DW'(v[0]));
      check("R4 R8 memory word", mem[i], (v[0] && !v[5]) ? nv : (INIT_BASE | DW'(i)));
    end
    ferr_inj = 1'b0; serr_inj = 1'b0;

    // R9: late data write after a suppressed store (flags 0001)
    base = store_cnt;
    wr_reg(2'd1, 32'h0000_1234);
    repeat (6) @(negedge clk);
    check("R9 late write issues no store", DW'(store_cnt - base), '0);
    rd_reg(2'd2, d); check("R9 late write keeps flags", d, 32'h1);
    pulse(3, '0);
    rd_reg(2'd2, d); check("R9 lock after close ignored", d, 32'h1);

    // R9: events after a successful store set nothing
    wr_reg(2'd0, 32'd9);
    rd_reg(2'd1, d);
    wr_reg(2'd1, 32'h0BAD_0009);
    repeat (8) @(negedge clk);
    pulse(1, AW'(9));
    pulse(4, '0);
    rd_reg(2'd2, d); check("R9 events after store ignored", d, '0);
    check("R4 store landed", mem[9], 32'h0BAD_0009);

    // R3: data read right after the address write stalls
    wr_reg(2'd0, 32'd10);
    xfer(1'b0, 2'd1, '0, 1'b0, '0, d, w);
    check("R3 read stalled during fetch", DW'(w >= 2), 32'd1);
    check("R3 stalled read value", d, INIT_BASE | 32'd10);

    // R11: data write right after the address write stalls, then stores
    wr_reg(2'd0, 32'd11);
    xfer(1'b1, 2'd1, 32'hC0DE_0011, 1'b0, '0, d, w);
    check("R11 write stalled during fetch", DW'(w >= 2), 32'd1);
    xfer(1'b1, 2'd0, 32'd11, 1'b0, '0, d, w);
    check("R11 address write stalled during store", DW'(w >= 1), 32'd1);
    repeat (8) @(negedge clk);
    rd_reg(2'd2, d); check("R11 flags after stalled write", d, '0);

    // R2 and R6: rewrite the address during an open reservation
    wr_reg(2'd0, 32'd12);
    rd_reg(2'd1, d);
    pulse(4, '0);
    rd_reg(2'd2, d); check("R6 interrupt flag", d, 32'h4);
    wr_reg(2'd0, 32'd13);
    rd_reg(2'd2, d); check("R2 rewrite clears flags", d, '0);
    rd_reg(2'd1, d); check("R1 refetched word", d, INIT_BASE | 32'd13);
    wr_reg(2'd1, 32'hFACE_0013);
    repeat (8) @(negedge clk);
    check("R4 store to new word", mem[13], 32'hFACE_0013);
    check("R2 old word untouched", mem[12], INIT_BASE | 32'd12);

    // R5: status write ignored, unused offset reads zero
    pulse(3, '0);
    wr_reg(2'd0, 32'd14);
    rd_reg(2'd1, d);
    pulse(3, '0);
    wr_reg(2'd2, 32'hFFFF_FFFF);
    rd_reg(2'd2, d); check("R5 status write ignored", d, 32'h2);
    rd_reg(2'd3, d); check("R5 unused offset", d, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule